// File: doc/BRIEF.md
# Wildcard Hash Key Expander

This block sits in front of a hash-table insertion path for longest-prefix-match tables. The hash index is built from a fixed list of selected key bit positions. When a stored prefix is shorter than some of those positions, the bits there are undefined, so the prefix cannot be hashed directly. The block takes one prefix with its length and the list of selected positions. It finds the k selected positions that fall in the prefix's undefined tail. It then produces 2^k concrete keys, one per cycle, that cover every combination of those bits. Each key can then be hashed and written by the downstream logic.

Undefined bits that no hash position looks at are never enumerated. They are simply driven to zero. This keeps the number of insertions at 2^k instead of the much larger count that full expansion to a fixed length would give. Keys leave through a valid/ready stream. Each key carries the original prefix length, so later matching still uses the true prefix length.

Top module: `wildcard_key_expander`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1.
- R2: Bit positions are counted from the key MSB: position p is key bit KEY_W-1-p. The selection list holds SEL_N entries of POS_W bits each, and entry i sits at in_sel[i*POS_W +: POS_W]. A selected position p is a fill position when p >= max(in_len, 8). The block emits exactly 2^k keys per accepted prefix, where k is the number of distinct fill positions.
- R3: In every emitted key, each position below max(in_len, 8) equals the accepted prefix bit. Each non-fill position at or above that length is 0, whatever the prefix held there.
- R4: Key n (counting from 0) places bit i of n at the i-th fill position, in ascending list-index order. Keys therefore come out in ascending binary order of the filled bits.
- R5: out_last is 1 on the final key of a prefix and 0 on every earlier key.
- R6: out_len equals the accepted in_len on every key of that prefix.
- R7: The first key is valid in the cycle after acceptance. When k = 0, that key is the only one and carries out_last.
- R8: in_ready is 0 while keys remain, except in a cycle where the final key is being taken. A prefix offered in that cycle is accepted, and its first key follows in the next cycle.
- R9: While out_valid is 1 and out_ready is 0, out_key, out_len and out_last stay unchanged and out_valid stays 1.
- R10: A position listed more than once counts as a single fill position. Only its lowest-index entry takes a counter bit.
- R11: Prefix lengths below 8 are treated as 8 for expansion. Selected positions 0..7 are never filled, while out_len still reports the given length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Prefix offered |
| in_ready | output | 1 | Prefix can be accepted this cycle |
| in_prefix | input | KEY_W (32) | Prefix value, MSB-aligned |
| in_len | input | LEN_W (6) | Prefix length in bits |
| in_sel | input | SEL_N*POS_W (40) | Selected hash positions, entry i at [i*POS_W +: POS_W] |
| out_valid | output | 1 | Expanded key valid |
| out_ready | input | 1 | Downstream takes the key |
| out_key | output | KEY_W (32) | Expanded key |
| out_len | output | LEN_W (6) | Original prefix length |
| out_last | output | 1 | Final key of this prefix |

## Verification
Two events can fall in one cycle: the handover of a prefix's final key and the acceptance of the next prefix. The bench holds a second prefix at the input while the first one streams out. It checks that in_ready stays low on every earlier key and rises only while the final key is being taken. In the following cycle, the first key of the second prefix must already be present with the second prefix's length, with no idle cycle between them.

// File: rtl/wke_pkg.sv
package wke_pkg;
  localparam int unsigned WKE_MIN_LEN = 8;

  typedef enum logic [0:0] {
    WKE_IDLE = 1'b0,
    WKE_EMIT = 1'b1
  } wke_state_e;
endpackage

// File: rtl/wke_classify.sv
module wke_classify #(
  parameter int KEY_W   = 32,
  parameter int SEL_N   = 8,
  parameter int MIN_LEN = 8,
  parameter int POS_W   = $clog2(KEY_W),
  parameter int LEN_W   = $clog2(KEY_W + 1),
  parameter int KW      = $clog2(SEL_N + 1)
) (
  input  logic [LEN_W-1:0]       len,
  input  logic [SEL_N*POS_W-1:0] sel,
  output logic [SEL_N-1:0]       wild,
  output logic [KW-1:0]          k,
  output logic [KEY_W-1:0]       keep
);
  logic [LEN_W-1:0] eff_len;
  logic [POS_W-1:0] pi;

  // lengths below the floor are raised to it
  assign eff_len = (len < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : len;

  // a position is a fill position when it lies past the effective length
  // and no lower-index entry names the same position
  always_comb begin
    wild = '0;
    pi   = '0;
    for (int i = 0; i < SEL_N; i++) begin
      pi      = sel[i*POS_W +: POS_W];
      wild[i] = (LEN_W'(pi) >= eff_len);
      for (int j = 0; j < i; j++) begin
        if (sel[j*POS_W +: POS_W] == pi) wild[i] = 1'b0;
      end
    end
  end

  assign k = KW'($countones(wild));

  // bits inside the effective length are copied from the prefix
  always_comb begin
    for (int b = 0; b < KEY_W; b++) begin
      keep[b] = (LEN_W'(KEY_W - 1 - b) < eff_len);
    end
  end
endmodule

// File: rtl/wke_scatter.sv
module wke_scatter #(
  parameter int KEY_W = 32,
  parameter int SEL_N = 8,
  parameter int POS_W = $clog2(KEY_W),
  parameter int RW    = $clog2(SEL_N)
) (
  input  logic [KEY_W-1:0]       base,
  input  logic [SEL_N*POS_W-1:0] sel,
  input  logic [SEL_N-1:0]       wild,
  input  logic [SEL_N-1:0]       cnt,
  output logic [KEY_W-1:0]       key
);
  logic [RW:0]      rank;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] bit_idx;

  // each fill entry takes the next counter bit, lowest list index first
  always_comb begin
    key     = base;
    rank    = '0;
    pos     = '0;
    bit_idx = '0;
    for (int i = 0; i < SEL_N; i++) begin
      pos     = sel[i*POS_W +: POS_W];
      bit_idx = POS_W'(KEY_W - 1) - pos;
      if (wild[i]) begin
        key[bit_idx] = cnt[rank[RW-1:0]];
        rank         = rank + (RW+1)'(1);
      end
    end
  end
endmodule

// File: rtl/wke_ctrl.sv
module wke_ctrl #(
  parameter int SEL_N = 8,
  parameter int KW    = $clog2(SEL_N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic [KW-1:0]    k_new,
  input  logic [KW-1:0]    k_cur,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_last,
  output logic             accept,
  output logic             step,
  output logic [SEL_N-1:0] cnt_next
);
  import wke_pkg::*;

  wke_state_e       state_q;
  logic [SEL_N-1:0] cnt_q;
  logic [SEL_N-1:0] cnt_inc;
  logic             last_q;
  logic             take;

  function automatic logic [SEL_N-1:0] fill_mask(input logic [KW-1:0] kk);
    return ~({SEL_N{1'b1}} << kk);
  endfunction

  assign out_valid = (state_q == WKE_EMIT);
  assign out_last  = last_q;
  assign take      = out_valid && out_ready;
  assign in_ready  = !out_valid || (out_ready && last_q);
  assign accept    = in_valid && in_ready;
  assign step      = take && !last_q;
  assign cnt_inc   = cnt_q + {{(SEL_N-1){1'b0}}, 1'b1};
  assign cnt_next  = accept ? '0 : cnt_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WKE_IDLE;
      cnt_q   <= '0;
      last_q  <= 1'b0;
    end else if (accept) begin
      state_q <= WKE_EMIT;
      cnt_q   <= '0;
      last_q  <= (k_new == '0);
    end else if (step) begin
      cnt_q   <= cnt_inc;
      last_q  <= (cnt_inc == fill_mask(k_cur));
    end else if (take) begin
      state_q <= WKE_IDLE;
      last_q  <= 1'b0;
    end
  end

  p_first_key_r7: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid && (cnt_q == '0));

  p_single_key_r7: assert property (@(posedge clk) disable iff (rst)
    accept && (k_new == '0) |=> out_last);

  p_next_index_r4: assert property (@(posedge clk) disable iff (rst)
    step |=> out_valid && (cnt_q == $past(cnt_inc)));

  p_last_at_top_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_last |-> (cnt_q == fill_mask(k_cur)));

  p_drain_r8: assert property (@(posedge clk) disable iff (rst)
    take && last_q && !in_valid |=> !out_valid);
endmodule

// File: rtl/wildcard_key_expander.sv
module wildcard_key_expander #(
  parameter int KEY_W   = 32,
  parameter int SEL_N   = 8,
  parameter int MIN_LEN = wke_pkg::WKE_MIN_LEN,
  localparam int POS_W  = $clog2(KEY_W),
  localparam int LEN_W  = $clog2(KEY_W + 1),
  localparam int KW     = $clog2(SEL_N + 1),
  localparam int RW     = $clog2(SEL_N)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [KEY_W-1:0]       in_prefix,
  input  logic [LEN_W-1:0]       in_len,
  input  logic [SEL_N*POS_W-1:0] in_sel,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [KEY_W-1:0]       out_key,
  output logic [LEN_W-1:0]       out_len,
  output logic                   out_last
);
  logic [SEL_N-1:0]       wild_in;
  logic [KW-1:0]          k_in;
  logic [KEY_W-1:0]       keep_in;
  logic [KEY_W-1:0]       base_in;

  logic [KEY_W-1:0]       base_q;
  logic [KEY_W-1:0]       keep_q;
  logic [SEL_N*POS_W-1:0] sel_q;
  logic [SEL_N-1:0]       wild_q;
  logic [KW-1:0]          k_q;
  logic [LEN_W-1:0]       len_q;
  logic [KEY_W-1:0]       key_q;

  logic                   accept;
  logic                   step;
  logic [SEL_N-1:0]       cnt_next;

  logic [KEY_W-1:0]       sc_base;
  logic [SEL_N*POS_W-1:0] sc_sel;
  logic [SEL_N-1:0]       sc_wild;
  logic [KEY_W-1:0]       sc_key;

  wke_classify #(
    .KEY_W(KEY_W), .SEL_N(SEL_N), .MIN_LEN(MIN_LEN),
    .POS_W(POS_W), .LEN_W(LEN_W), .KW(KW)
  ) u_classify (
    .len  (in_len),
    .sel  (in_sel),
    .wild (wild_in),
    .k    (k_in),
    .keep (keep_in)
  );

  assign base_in = in_prefix & keep_in;

  wke_ctrl #(.SEL_N(SEL_N), .KW(KW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .k_new     (k_in),
    .k_cur     (k_q),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .accept    (accept),
    .step      (step),
    .cnt_next  (cnt_next)
  );

  // one scatter serves both the first key of a new prefix and later keys
  assign sc_base = accept ? base_in : base_q;
  assign sc_sel  = accept ? in_sel  : sel_q;
  assign sc_wild = accept ? wild_in : wild_q;

  wke_scatter #(.KEY_W(KEY_W), .SEL_N(SEL_N), .POS_W(POS_W), .RW(RW)) u_scatter (
    .base (sc_base),
    .sel  (sc_sel),
    .wild (sc_wild),
    .cnt  (cnt_next),
    .key  (sc_key)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      keep_q <= '0;
      sel_q  <= '0;
      wild_q <= '0;
      k_q    <= '0;
      len_q  <= '0;
    end else if (accept) begin
      base_q <= base_in;
      keep_q <= keep_in;
      sel_q  <= in_sel;
      wild_q <= wild_in;
      k_q    <= k_in;
      len_q  <= in_len;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 key_q <= '0;
    else if (accept || step) key_q <= sc_key;
  end

  assign out_key = key_q;
  assign out_len = len_q;

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_key)
                                && $stable(out_len) && $stable(out_last));

  p_len_kept_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_last |=> $stable(out_len));

  p_prefix_bits_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (((out_key ^ base_q) & keep_q) == '0));
endmodule

// File: tb/sim_wildcard_key_expander.sv
module sim_wildcard_key_expander;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_prefix;
  logic [5:0]  in_len;
  logic [39:0] in_sel;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_key;
  logic [5:0]  out_len;
  logic        out_last;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wildcard_key_expander u0 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_prefix(in_prefix), .in_len(in_len), .in_sel(in_sel),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_key(out_key), .out_len(out_len), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] pk(input int a, input int b, input int c, input int d,
                                     input int e, input int f, input int g, input int h);
    logic [39:0] s;
    s[4:0]   = 5'(a); s[9:5]   = 5'(b); s[14:10] = 5'(c); s[19:15] = 5'(d);
    s[24:20] = 5'(e); s[29:25] = 5'(f); s[34:30] = 5'(g); s[39:35] = 5'(h);
    return s;
  endfunction

  function automatic int eff(input logic [5:0] len);
    return (int'(len) < 8) ? 8 : int'(len);
  endfunction

  function automatic bit is_fill(input logic [5:0] len, input logic [39:0] sel, input int i);
    int p = int'(sel[i*5 +: 5]);
    if (p < eff(len)) return 1'b0;
    for (int j = 0; j < i; j++) if (int'(sel[j*5 +: 5]) == p) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int exp_k(input logic [5:0] len, input logic [39:0] sel);
    int k = 0;
    for (int i = 0; i < 8; i++) if (is_fill(len, sel, i)) k++;
    return k;
  endfunction

  function automatic logic [31:0] exp_key(input logic [31:0] pfx, input logic [5:0] len,
                                          input logic [39:0] sel, input int n);
    logic [31:0] key = '0;
    int r = 0;
    for (int p = 0; p < 32; p++) if (p < eff(len)) key[31-p] = pfx[31-p];
    for (int i = 0; i < 8; i++) begin
      if (is_fill(len, sel, i)) begin
        key[31 - int'(sel[i*5 +: 5])] = n[r];
        r++;
      end
    end
    return key;
  endfunction

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    in_prefix = '0; in_len = '0; in_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 1);
  endtask

  // offers one prefix, then drains and checks every key
  task automatic run_case(input string name, input logic [31:0] pfx, input logic [5:0] len,
                          input logic [39:0] sel, input bit stall);
    int total = 1 << exp_k(len, sel);
    logic [31:0] held_key;
    logic        held_last;
    @(negedge clk);
    in_prefix = pfx; in_len = len; in_sel = sel; in_valid = 1'b1; out_ready = 1'b0;
    #1 chk(in_ready == 1'b1, "R8", {name, " ready when idle"}, 64'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0; in_prefix = ~pfx; in_len = ~len; in_sel = ~sel;
    #1 chk(out_valid == 1'b1, "R7", {name, " valid after accept"}, 64'(out_valid), 1);
    for (int n = 0; n < total; n++) begin
      if (stall && (n % 3 == 1)) begin
        out_ready = 1'b0;
        #1 held_key = out_key; held_last = out_last;
        chk(in_ready == 1'b0, "R8", {name, " ready while stalled"}, 64'(in_ready), 0);
        @(negedge clk); #1;
        chk(out_valid && out_key == held_key && out_last == held_last, "R9",
            {name, " key held under stall"}, 64'(out_key), 64'(held_key));
      end
      out_ready = 1'b1;
      #1;
      chk(out_key == exp_key(pfx, len, sel, n), "R4", $sformatf("%s key %0d", name, n),
          64'(out_key), 64'(exp_key(pfx, len, sel, n)));
      chk(out_last == (n == total - 1), "R5", $sformatf("%s last on key %0d", name, n),
          64'(out_last), 64'(n == total - 1));
      chk(out_len == len, "R6", $sformatf("%s length on key %0d", name, n),
          64'(out_len), 64'(len));
      chk(in_ready == (n == total - 1), "R8", $sformatf("%s ready on key %0d", name, n),
          64'(in_ready), 64'(n == total - 1));
      @(negedge clk);
    end
    out_ready = 1'b0;
    #1 chk(out_valid == 1'b0, "R2", {name, " no key past 2^k"}, 64'(out_valid), 0);
  endtask

  // second prefix waits at the input and enters on the final take of the first
  task automatic back_to_back();
    logic [31:0] pa = 32'hC0A8_0117;
    logic [5:0]  la = 6'd30;
    logic [39:0] sa = pk(30, 2, 31, 4, 9, 12, 20, 6);
    logic [31:0] pb = 32'h0A0B_0C0D;
    logic [5:0]  lb = 6'd32;
    logic [39:0] sb = pk(0, 31, 15, 8, 1, 2, 3, 4);
    @(negedge clk);
    in_prefix = pa; in_len = la; in_sel = sa; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_prefix = pb; in_len = lb; in_sel = sb; in_valid = 1'b1;
    for (int n = 0; n < 4; n++) begin
      out_ready = 1'b1;
      #1;
      chk(out_key == exp_key(pa, la, sa, n), "R4", $sformatf("b2b first key %0d", n),
          64'(out_key), 64'(exp_key(pa, la, sa, n)));
      chk(in_ready == (n == 3), "R8", $sformatf("b2b ready on key %0d", n),
          64'(in_ready), 64'(n == 3));
      @(negedge clk);
    end
    in_valid = 1'b0;
    #1;
    chk(out_valid == 1'b1, "R8", "b2b second prefix valid at once", 64'(out_valid), 1);
    chk(out_key == exp_key(pb, lb, sb, 0), "R8", "b2b second prefix key",
        64'(out_key), 64'(exp_key(pb, lb, sb, 0)));
    chk(out_len == lb, "R6", "b2b second prefix length", 64'(out_len), 64'(lb));
    chk(out_last == 1'b1, "R7", "b2b k=0 single key", 64'(out_last), 1);
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R2", "b2b drained", 64'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R7: every selected position inside the length, one key
    run_case("k0", 32'hDEAD_BEEF, 6'd24, pk(0, 3, 7, 9, 12, 18, 22, 23), 1'b0);
    // R2 R3: two fill positions, junk past the length cleared
    run_case("k2", 32'h1234_FFFF, 6'd16, pk(1, 3, 5, 9, 12, 15, 20, 28), 1'b0);
    // R10: repeated positions counted once
    run_case("dup", 32'hA5A5_5A5A, 6'd20, pk(25, 25, 22, 3, 22, 30, 10, 31), 1'b1);
    // R11: short length raised to 8, low positions never filled
    run_case("short", 32'hF3C0_0000, 6'd4, pk(2, 5, 9, 0, 7, 1, 6, 3), 1'b0);
    // R2 R4 R9: all eight positions filled, 256 keys with stalls
    run_case("k8", 32'h8100_0000, 6'd8, pk(8, 11, 14, 17, 20, 23, 26, 31), 1'b1);
    back_to_back();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule